// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Periodic Strobes

This block is a 12-bit up-counter that keeps time in microseconds. The surrounding logic supplies a one-cycle enable once per microsecond, and the counter moves forward by one on each enable. The counter cannot be stopped and rolls over from 0xFFF to 0x000.

Two counter bits are watched, and each produces a periodic interrupt strobe. The fast strobe fires when bit 6 falls, which happens every 128 µs. The slow strobe fires when bit 9 falls, which happens every 1.024 ms. Each strobe is a single clock wide. An interrupt controller elsewhere latches and prioritises these strobes.

Software reads the count through a byte-wide port that has two addresses. Reading the low byte also saves the top nibble of the count into a shadow register. A high-byte read that follows returns that saved nibble, so the two bytes belong to the same instant even if the counter has moved in between.

Top module: `usec_timer`

## Requirements
- R1: Reset is synchronous and active low. It clears the count to 0, the high-nibble shadow to 0, the read data register to 0x00 and both strobes to 0.
- R2: Each clock cycle with `tick_en` high adds one to the count. With `tick_en` low the count holds its value.
- R3: After 0xFFF the next tick gives 0x000.
- R4: `irq_128us` is high for exactly one clock. That clock directly follows the tick that takes the count from a value whose bits 6:0 are all ones, so bit 6 falls from 1 to 0. This gives one pulse every 128 ticks.
- R5: `irq_1024us` follows the same rule on bit 9 (bits 9:0 all ones before the tick). This gives one pulse every 1024 ticks.
- R6: A read with `rd_en` high and `rd_sel` = 0 (low byte) puts count bits 7:0 into `rd_data` on the next clock. The value is the count as it stood in the read cycle, before any tick in that same cycle. The same read saves count bits 11:8 into the shadow.
- R7: A read with `rd_sel` = 1 (high byte) returns the shadow in bits 3:0 of `rd_data` and zero in bits 7:4. Ticks between the low read and the high read do not change what the high read returns. Before any low read the shadow is 0.
- R8: `rd_data` holds its last value while `rd_en` is low. Reads never change the count.
- R9: At rollover both strobes pulse in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle enable, once per microsecond |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| rd_data | output | 8 | Registered read data |
| irq_128us | output | 1 | One-clock strobe every 128 ticks |
| irq_1024us | output | 1 | One-clock strobe every 1024 ticks |

## Verification
Rollover is the hardest case to reach from the ports. It needs 4095 ticks to reach 0xFFF and then one more tick, at which point both strobes must fire together.

The vector table drives the counter through long runs of ticks that cross several 128-tick and 1024-tick boundaries and end exactly at rollover. A cycle-accurate model in the bench checks the position of every strobe during these runs.

The coherence of the shadow needs a low read, then a run of ticks that changes the top nibble, then a high read. A directed sequence sets this up, including a low read issued in the same cycle as a tick.

// File: rtl/usec_timer_pkg.sv
// Shared definitions for the microsecond timer.
// Assumes the byte select is a single bit: low byte at 0, high byte at 1.
package usec_timer_pkg;
    typedef enum logic {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } byte_sel_e;

    localparam int DEF_CNT_W  = 12;
    localparam int DEF_BYTE_W = 8;
endpackage

// File: rtl/usec_counter.sv
// Free-running up-counter. It advances by one on every cycle with tick_en high
// and wraps at 2**CNT_W. It cannot be stopped except by reset.
// Assumes: tick_en is synchronous to clk; reset is synchronous, active low.
module usec_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);
    // Count register: clear on reset, otherwise step on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (tick_en) count <= count + 1'b1;
    end

    // R2 R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count == CNT_W'($past(count) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));
endmodule

// File: rtl/usec_tap_strobe.sv
// Strobe generator for one counter tap. It pulses for one clock after the
// tick that makes bit TAP fall from 1 to 0.
// Assumes: tap_bits are count bits TAP..0 of the free-running counter.
module usec_tap_strobe #(
    parameter int TAP = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic [TAP:0] tap_bits,
    output logic         strobe
);
    logic fall_next;

    // Bit TAP falls on the next tick exactly when bits TAP..0 are all ones.
    always_comb fall_next = tick_en && (&tap_bits);

    // Register the strobe so that it lines up with the updated count.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= fall_next;
    end

    // R4 R5
    strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> tap_bits == '0);

    // R4 R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R4 R5
    strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> !strobe);
endmodule

// File: rtl/usec_readout.sv
// Byte-wide read port for the counter. A low-byte read returns count bits
// BYTE_W-1..0 and saves the upper bits into a shadow. A high-byte read returns
// that shadow, zero-extended.
// Assumes: BYTE_W < CNT_W <= 2*BYTE_W.
module usec_readout
    import usec_timer_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_sel,
    input  logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int HI_W  = CNT_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W;

    logic [HI_W-1:0]   shadow_q;
    logic [BYTE_W-1:0] rd_mux;

    // Choose the byte for the current read.
    always_comb begin
        if (rd_sel == SEL_HIGH) rd_mux = {{PAD_W{1'b0}}, shadow_q};
        else                    rd_mux = count[BYTE_W-1:0];
    end

    // Shadow capture on every low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)                          shadow_q <= '0;
        else if (rd_en && rd_sel == SEL_LOW) shadow_q <= count[CNT_W-1:BYTE_W];
    end

    // Read data register: load on a read, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    // R6
    low_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_LOW) |=> rd_data == $past(count[BYTE_W-1:0]));

    // R7
    high_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_HIGH) |=> rd_data[BYTE_W-1:HI_W] == '0);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/usec_timer.sv
// Free-running microsecond timer. It contains a CNT_W-bit counter stepped by
// tick_en, two tap strobes (fast on bit TAP_FAST, slow on bit TAP_SLOW) and
// a byte-wide read port with a coherent high-byte shadow.
// Assumes: tick_en is high for one clock per microsecond; reset is synchronous
// and active low.
module usec_timer
    import usec_timer_pkg::*;
#(
    parameter int CNT_W    = DEF_CNT_W,
    parameter int BYTE_W   = DEF_BYTE_W,
    parameter int TAP_FAST = 6,
    parameter int TAP_SLOW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq_128us,
    output logic              irq_1024us
);
    localparam int N_TAPS = 2;
    localparam int TAP_POS [N_TAPS] = '{TAP_FAST, TAP_SLOW};

    logic [CNT_W-1:0]  count_q;
    logic [N_TAPS-1:0] strobes;

    usec_counter #(.CNT_W(CNT_W)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count   (count_q)
    );

    // One strobe generator per tap.
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        usec_tap_strobe #(.TAP(TAP_POS[g])) i_tap (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_en),
            .tap_bits (count_q[TAP_POS[g]:0]),
            .strobe   (strobes[g])
        );
    end

    assign irq_128us  = strobes[0];
    assign irq_1024us = strobes[1];

    usec_readout #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) i_readout (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .count   (count_q),
        .rd_data (rd_data)
    );

    // R9
    wrap_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_1024us) |-> irq_128us);
endmodule

// File: tb/test_usec_timer.sv
module test_usec_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       irq_128us;
    logic       irq_1024us;

    int n_chk = 0;
    int n_fail = 0;
    logic [11:0] exp_cnt = '0;

    always #5 clk = ~clk;

    usec_timer i_usec_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_128us(irq_128us), .irq_1024us(irq_1024us)
    );

    // Vector entry fields: ticks[47:32], low[31:24], high[23:16], fast[15:8], slow[7:0]
    localparam int N_VEC = 6;
    localparam logic [47:0] VEC [N_VEC] = '{
        {16'd5,    8'h05, 8'h00, 8'd0,  8'd0},
        {16'd123,  8'h80, 8'h00, 8'd1,  8'd0},
        {16'd300,  8'hAC, 8'h01, 8'd2,  8'd0},
        {16'd600,  8'h04, 8'h04, 8'd5,  8'd1},
        {16'd3067, 8'hFF, 8'h0F, 8'd23, 8'd2},
        {16'd1,    8'h00, 8'h00, 8'd1,  8'd1}
    };

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Tick n times; check each strobe against the bench model every cycle.
    task automatic run_ticks(input int n, output int nf, output int ns, output int bad);
        nf = 0; ns = 0; bad = 0;
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            exp_cnt = exp_cnt + 12'd1;
            if (irq_128us != (exp_cnt[6:0] == 7'd0)) bad++;
            if (irq_1024us != (exp_cnt[9:0] == 10'd0)) bad++;
            if (irq_128us) nf++;
            if (irq_1024us) ns++;
        end
        tick_en = 1'b0;
    endtask

    task automatic read_reg(input logic sel, output logic [7:0] d);
        rd_en = 1'b1;
        rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int nf, ns, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "rd_data after reset", rd_data, 0);
        check("R1", "irq_128us after reset", irq_128us, 0);
        check("R1", "irq_1024us after reset", irq_1024us, 0);
        read_reg(1'b1, d);
        check("R1", "shadow before any low read", d, 0);

        // R2 R3 R4 R5 R9 vector walk
        for (int v = 0; v < N_VEC; v++) begin
            run_ticks(int'(VEC[v][47:32]), nf, ns, bad);
            check("R4", "strobe positions", bad, 0);
            check("R4", "fast pulse count", nf, int'(VEC[v][15:8]));
            check("R5", "slow pulse count", ns, int'(VEC[v][7:0]));
            read_reg(1'b0, d);
            check("R2", "low byte", d, int'(VEC[v][31:24]));
            read_reg(1'b1, d);
            check("R7", "high byte", d, int'(VEC[v][23:16]));
        end

        // R3 rollover was the last vector; counter is now 0
        read_reg(1'b0, d);
        check("R3", "count after wrap", d, 0);

        // R7 coherence: low read, ticks move the nibble, high read keeps old one
        run_ticks(300, nf, ns, bad);
        read_reg(1'b0, d);
        check("R6", "low byte at 0x12C", d, 8'h2C);
        run_ticks(1000, nf, ns, bad);
        check("R5", "strobe positions 300..1300", bad, 0);
        read_reg(1'b1, d);
        check("R7", "high byte keeps saved nibble", d, 8'h01);
        read_reg(1'b0, d);
        check("R6", "low byte at 0x514", d, 8'h14);
        read_reg(1'b1, d);
        check("R7", "high byte after fresh low read", d, 8'h05);

        // R8 hold while idle; no strobes and no count change without ticks
        repeat (6) @(negedge clk);
        check("R8", "rd_data held while idle", rd_data, 8'h05);
        check("R2", "no strobe without ticks", irq_128us | irq_1024us, 0);
        read_reg(1'b0, d);
        check("R2", "count held without ticks", d, 8'h14);

        // R6 low read in the same cycle as a tick returns pre-tick value
        tick_en = 1'b1;
        read_reg(1'b0, d);
        tick_en = 1'b0;
        exp_cnt = exp_cnt + 12'd1;
        check("R6", "read concurrent with tick", d, 8'h14);
        read_reg(1'b0, d);
        check("R8", "count after concurrent read", d, 8'h15);

        // R1 reset mid-run clears count and shadow
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = '0;
        check("R1", "rd_data after second reset", rd_data, 0);
        read_reg(1'b1, d);
        check("R1", "shadow after second reset", d, 0);
        read_reg(1'b0, d);
        check("R1", "count after second reset", d, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule